// File: doc/BRIEF.md
# Read/Write Mix Detector and Arbiter Selector

This block watches the stream of memory requests arriving at a controller and decides which of three history-based arbiters should be active. It counts the first-time reads and writes over a fixed window of cycles. At the end of each window it sorts the read/write ratio into one of three bands. It then presents the band as a registered 2-bit select code, together with a one-cycle update strobe. Requests flagged as re-sent do not enter the counts, so a backlog of retries cannot bias the estimate.

The ratio is never divided. Each band edge is tested as a cross-multiplied comparison in which the constant factors are built from left shifts and adds. The selected arbiters sit outside the block and only consume the select code. The window length and counter width are parameters. The default window is 10000 cycles.

Top module: `mix_arb_selector`

## Requirements
- R1: While reset is asserted and after its release, `sel_o` reads 2'b00 (balanced arbiter) and `upd_o` is 0 until the first window closes.
- R2: The window is `PERIOD` cycles long. `upd_o` is high for exactly one cycle after the last cycle of each window and low otherwise. Pulses sampled in the last cycle of a window count toward that window. Both counts restart from zero for the next window, and `sel_o` changes only on the cycle `upd_o` is high.
- R3: With read count R and write count W for the closing window, `5*R > 6*W` (ratio above 1.2) selects code 2'b01, the read-heavy arbiter.
- R4: `5*R < 4*W` (ratio below 0.8) selects code 2'b10, the write-heavy arbiter.
- R5: Exact boundary ratios (`5*R == 6*W` or `5*R == 4*W`) and every ratio between them select code 2'b00.
- R6: A window with W = 0 and R > 0 selects code 2'b01.
- R7: A window with R = 0 and W = 0 leaves `sel_o` at its previous value, while `upd_o` still pulses.
- R8: A cycle with `retry_i` high adds nothing to either count, whatever the pulses.
- R9: A read pulse and a write pulse in the same cycle are both counted.
- R10: Each count saturates at 2^`CNT_W`-1 and never wraps within a window.
- R11: `sel_o` never carries code 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_new_i | input | 1 | One read request received this cycle |
| wr_new_i | input | 1 | One write request received this cycle |
| retry_i | input | 1 | This cycle's request pulses are re-sends; do not count |
| sel_o | output | 2 | Arbiter select: 00 balanced, 01 read-heavy, 10 write-heavy |
| upd_o | output | 1 | One-cycle strobe: a new window result is on `sel_o` |

## Verification
Directed windows place the counts exactly on both band edges and one step beyond each. This separates a strict from a non-strict comparison and a wrong shift factor. Other directed windows cover only reads, only writes, no traffic, and a window that overfills the read counter, which tell keeping the old select apart from falling to a default and saturation apart from wrap-around. A window rich in retried reads flips the expected band if retries leak into the count. A window of paired read/write pulses shows whether a simultaneous pair is counted once or twice. Seeded random windows with mixed retry density then compare every band decision against a reference computed by true multiplication.

// File: rtl/mix_sel_pkg.sv
package mix_sel_pkg;

  typedef enum logic [1:0] {
    SEL_BAL  = 2'b00,
    SEL_RD   = 2'b01,
    SEL_WR   = 2'b10,
    SEL_RSVD = 2'b11
  } arb_sel_e;

  // Constant factors of the band tests, each realised as shift/add.
  localparam int unsigned HEADROOM = 3;

endpackage

// File: rtl/mix_sat_counter.sv
module mix_sat_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] tot_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] tot;
  logic             cnt_en;

  // Total including this cycle's pulse, held at the ceiling.
  always_comb begin
    if (inc_i && (cnt_q != CNT_MAX)) tot = cnt_q + CNT_W'(1);
    else                             tot = cnt_q;
  end

  always_comb begin
    cnt_en = inc_i | clr_i;
    cnt_d  = clr_i ? '0 : tot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign tot_o = tot;

  p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (cnt_q >= $past(cnt_q)));

  p_sat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == CNT_MAX) && !clr_i) |=> (cnt_q == CNT_MAX));

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/mix_window_timer.sv
module mix_window_timer #(
  parameter int unsigned PERIOD = 10000
) (
  input  logic clk,
  input  logic rst_n,
  output logic last_o
);

  localparam int unsigned TMR_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(PERIOD - 1);

  logic [TMR_W-1:0] tmr_q;
  logic [TMR_W-1:0] tmr_d;
  logic             at_last;

  always_comb begin
    at_last = (tmr_q == TMR_LAST);
    tmr_d   = at_last ? '0 : tmr_q + TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  assign last_o = at_last;

  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    at_last |=> (tmr_q == '0));

  p_single_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    at_last |=> !at_last);

endmodule

// File: rtl/mix_ratio_band.sv
module mix_ratio_band
  import mix_sel_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] rd_i,
  input  logic [CNT_W-1:0] wr_i,
  output logic             hi_o,
  output logic             lo_o,
  output logic             any_o
);

  localparam int unsigned EXT_W = CNT_W + HEADROOM;

  logic [EXT_W-1:0] rd_x;
  logic [EXT_W-1:0] wr_x;
  logic [EXT_W-1:0] rd_x5;
  logic [EXT_W-1:0] wr_x6;
  logic [EXT_W-1:0] wr_x4;

  always_comb begin
    rd_x  = {{HEADROOM{1'b0}}, rd_i};
    wr_x  = {{HEADROOM{1'b0}}, wr_i};
    rd_x5 = (rd_x << 2) + rd_x;
    wr_x6 = (wr_x << 2) + (wr_x << 1);
    wr_x4 = (wr_x << 2);
    hi_o  = (rd_x5 > wr_x6);
    lo_o  = (rd_x5 < wr_x4);
    any_o = (rd_i != '0) || (wr_i != '0);
  end

endmodule

// File: rtl/mix_arb_selector.sv
module mix_arb_selector
  import mix_sel_pkg::*;
#(
  parameter int unsigned PERIOD = 10000,
  parameter int unsigned CNT_W  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_new_i,
  input  logic       wr_new_i,
  input  logic       retry_i,
  output logic [1:0] sel_o,
  output logic       upd_o
);

  logic             win_end;
  logic             rd_inc;
  logic             wr_inc;
  logic [CNT_W-1:0] rd_cnt;
  logic [CNT_W-1:0] wr_cnt;
  logic [CNT_W-1:0] rd_tot;
  logic [CNT_W-1:0] wr_tot;
  logic             band_hi;
  logic             band_lo;
  logic             band_any;
  arb_sel_e         sel_q;
  arb_sel_e         sel_d;
  logic             sel_en;
  logic             upd_q;

  mix_window_timer #(.PERIOD(PERIOD)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .last_o(win_end)
  );

  assign rd_inc = rd_new_i & ~retry_i;
  assign wr_inc = wr_new_i & ~retry_i;

  mix_sat_counter #(.CNT_W(CNT_W)) u_rd_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .inc_i(rd_inc),
    .clr_i(win_end),
    .cnt_o(rd_cnt),
    .tot_o(rd_tot)
  );

  mix_sat_counter #(.CNT_W(CNT_W)) u_wr_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .inc_i(wr_inc),
    .clr_i(win_end),
    .cnt_o(wr_cnt),
    .tot_o(wr_tot)
  );

  mix_ratio_band #(.CNT_W(CNT_W)) u_band (
    .rd_i (rd_tot),
    .wr_i (wr_tot),
    .hi_o (band_hi),
    .lo_o (band_lo),
    .any_o(band_any)
  );

  always_comb begin
    sel_en = win_end & band_any;
    if (band_hi)      sel_d = SEL_RD;
    else if (band_lo) sel_d = SEL_WR;
    else              sel_d = SEL_BAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= SEL_BAL;
    else if (sel_en) sel_q <= sel_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= win_end;
  end

  assign sel_o = sel_q;
  assign upd_o = upd_q;

  p_sel_only_on_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_q |-> $stable(sel_q));

  p_legal_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q != SEL_RSVD);

  p_keep_on_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && (rd_tot == '0) && (wr_tot == '0)) |=> $stable(sel_q));

  p_retry_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_i && !win_end) |=> ((rd_cnt == $past(rd_cnt)) && (wr_cnt == $past(wr_cnt))));

  p_bands_disjoint_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(band_hi && band_lo));

  p_no_write_reads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && (wr_tot == '0) && (rd_tot != '0)) |=> (sel_q == SEL_RD));

endmodule

// File: tb/test_mix_arb_selector.sv
module test_mix_arb_selector;

  localparam int unsigned PER  = 40;
  localparam int unsigned CW   = 4;
  localparam int          CMAX = (1 << CW) - 1;

  logic       clk;
  logic       rst_n;
  logic       rd_new;
  logic       wr_new;
  logic       retry;
  logic [1:0] sel;
  logic       upd;

  int errors = 0;
  int checks = 0;
  logic [1:0] exp_prev;
  bit done = 0;

  mix_arb_selector #(.PERIOD(PER), .CNT_W(CW)) i_mix_arb_selector (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_new_i(rd_new),
    .wr_new_i(wr_new),
    .retry_i (retry),
    .sel_o   (sel),
    .upd_o   (upd)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [1:0] ref_sel(int r, int w, logic [1:0] prev);
    if (r == 0 && w == 0) return prev;
    if (5 * r > 6 * w)    return 2'b01;
    if (5 * r < 4 * w)    return 2'b10;
    return 2'b00;
  endfunction

  function automatic int sat(int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one window from a prebuilt per-cycle schedule, then checks the result.
  task automatic run_sched(string req, bit rv[PER], bit wv[PER], bit tv[PER]);
    int r = 0;
    int w = 0;
    bit stray = 0;
    for (int c = 0; c < PER; c++) begin
      rd_new = rv[c];
      wr_new = wv[c];
      retry  = tv[c];
      if (!tv[c]) begin
        r += rv[c];
        w += wv[c];
      end
      @(posedge clk);
      @(negedge clk);
      if (c < PER - 1 && upd !== 1'b0) stray = 1;
    end
    rd_new = 0; wr_new = 0; retry = 0;
    check({req, " R2 strobe"}, upd, 1'b1);
    check({req, " R2 no stray strobe"}, stray, 1'b0);
    exp_prev = ref_sel(sat(r), sat(w), exp_prev);
    check(req, sel, exp_prev);
  endtask

  task automatic run_dir(string req, int nboth, int nr, int nw, int nretry);
    bit rv[PER];
    bit wv[PER];
    bit tv[PER];
    int k = 0;
    for (int c = 0; c < PER; c++) begin rv[c] = 0; wv[c] = 0; tv[c] = 0; end
    for (int i = 0; i < nboth; i++) begin rv[k] = 1; wv[k] = 1; k++; end
    for (int i = 0; i < nr; i++)    begin rv[k] = 1; k++; end
    for (int i = 0; i < nw; i++)    begin wv[k] = 1; k++; end
    for (int i = 0; i < nretry; i++) begin rv[k] = 1; wv[k] = i[0]; tv[k] = 1; k++; end
    run_sched(req, rv, wv, tv);
  endtask

  task automatic run_rand(int pr, int pw, int pt);
    bit rv[PER];
    bit wv[PER];
    bit tv[PER];
    for (int c = 0; c < PER; c++) begin
      rv[c] = ($urandom % 100) < pr;
      wv[c] = ($urandom % 100) < pw;
      tv[c] = ($urandom % 100) < pt;
    end
    run_sched("R3/R4/R5/R8 random", rv, wv, tv);
  endtask

  initial begin
    rst_n = 0; rd_new = 0; wr_new = 0; retry = 0;
    exp_prev = 2'b00;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 sel in reset", sel, 2'b00);
    check("R1 upd in reset", upd, 1'b0);
    rst_n = 1;
    run_dir("R3 7R/5W", 0, 7, 5, 0);
    run_dir("R5 6R/5W upper edge", 0, 6, 5, 0);
    run_dir("R4 3R/5W", 0, 3, 5, 0);
    run_dir("R5 4R/5W lower edge", 0, 4, 5, 0);
    run_dir("R6 5R/0W", 0, 5, 0, 0);
    run_dir("R7 idle keeps", 0, 0, 0, 0);
    run_dir("R4 0R/3W", 0, 0, 3, 0);
    run_dir("R7 idle keeps write", 0, 0, 0, 0);
    run_dir("R10 20R/13W saturates", 0, 20, 13, 0);
    run_dir("R6 9R/0W", 0, 9, 0, 0);
    run_dir("R8 2R/5W plus retries", 0, 2, 5, 12);
    run_dir("R9 6 paired + 1R", 6, 1, 0, 0);
    run_dir("R9 paired only", 8, 0, 0, 0);
    for (int i = 0; i < 30; i++) begin
      case (i % 3)
        0:       run_rand(60, 30, 10);
        1:       run_rand(30, 60, 25);
        default: run_rand(45, 45, 40);
      endcase
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule